// File: doc/BRIEF.md
# Backlight Pulse-Width Modulator with Sample Queue

The block drives a panel backlight with a pulse-width modulated signal. A free-running up-counter, advanced by a selectable time base through a prescaler, sets the output period. The output is active from the start of each period until the counter reaches the active duty sample.

Software loads duty samples through a word-addressed register port. The samples go into a small queue. Each sample can be held for one, two, four or eight periods before the next one is taken. When the queue runs dry the last sample stays in use. A programmable watermark reports when enough queue slots are free, so that software can refill the queue before it empties. A self-clearing soft reset empties the queue and returns control and counter to their idle state.

The counter can advance on every bus clock, on one of two external tick strobes, or not at all. The tick strobes are single-cycle enables in the bus clock domain.

Top module: `bl_pwm`

## Requirements
- R1: After reset, every register reads zero, except status, which reads 0x18 (queue empty, watermark reached). `pwm_out` and `irq` are low.
- R2: With the period register P and the prescaler field D (control bits 15:4), one output period lasts (P+2)*(D+1) counts of the selected time base. The output is active for S*(D+1) of those counts, starting at the period start, where S is the active sample and S < P+2.
- R3: A sample of 0 keeps the output inactive for the whole period.
- R4: Control bit 18 inverts the output. While the block is disabled, `pwm_out` equals this bit.
- R5: Control bits 17:16 select the time base: 0 stops the counter, 1 is every bus clock, 2 is `hf_tick`, 3 is `lf_tick`. A strobe that is not selected has no effect.
- R6: A write to the sample offset (word 3) pushes bits 15:0 into a 4-entry queue. A write to a full queue is dropped. Samples leave the queue in the order they were written.
- R7: Control bits 2:1 (values 0, 1, 2, 3) give each sample 1, 2, 4 or 8 consecutive periods.
- R8: When the queue is empty at a sample change, the previous sample is reused. Status bits 2:0 give the queue fill level, and status bit 3 is set while the queue is empty.
- R9: Control bits 27:26 (values 0 to 3) set a threshold of 1 to 4 free slots. Status bit 4 is set while the free slots are at least the threshold. `irq` is status bit 4 AND interrupt-enable bit 0 (word 2).
- R10: Writing control bit 3 stores the written word for one cycle. Then the control register, the queue and the counter clear, so control reads 0 and the block is disabled.
- R11: Registers sit at word offsets 0 to 5: control, status, interrupt enable, sample (reads the active sample), period, and counter (reads the 16-bit counter). Control bit 0 enables counting, and the counter restarts from 0 when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hf_tick | input | 1 | High-frequency time base strobe |
| lf_tick | input | 1 | Low-frequency time base strobe |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with `bus_sel` |
| bus_addr | input | 3 | Word offset (byte address bits 4:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | Modulated output |
| irq | output | 1 | Watermark interrupt |

## Verification
The hardest cases to reach from the ports are the exact sample sequence across queue overflow, repetition and underrun. These are only visible as the active time of successive periods. The bench fills the queue past capacity while the block is disabled, then enables it. It then measures active time period by period from the first rising edge, and compares the sequence against a list built from the write order, the repeat count and the rule that the last sample is reused. Tick-driven time bases are reached by holding the strobes low, pulsing them a known number of times, and reading the counter back.

// File: rtl/bl_pwm.sv
module bl_pwm #(
  parameter int CW     = 16,
  parameter int FDEPTH = 4,
  parameter int PW     = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hf_tick,
  input  logic        lf_tick,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:2]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        pwm_out,
  output logic        irq
);
  localparam int AW   = $clog2(FDEPTH);
  localparam int CNTW = $clog2(FDEPTH + 1);

  logic [31:0]     ctrl_q, ie_q;
  logic [CW-1:0]   period_q, duty_q;
  logic [CW:0]     cnt;
  logic            running;
  logic [PW-1:0]   pre_cnt;
  logic [2:0]      rep_cnt;
  logic [CW-1:0]   mem [FDEPTH];
  logic [AW-1:0]   rd_ptr, wr_ptr;
  logic [CNTW-1:0] fcnt;

  wire             en     = ctrl_q[0];
  wire [1:0]       rep_sel = ctrl_q[2:1];
  wire             swrst  = ctrl_q[3];
  wire [PW-1:0]    presc  = ctrl_q[4 +: PW];
  wire [1:0]       src_sel = ctrl_q[17:16];
  wire             pol    = ctrl_q[18];
  wire [1:0]       wm_sel = ctrl_q[27:26];

  wire wr_any    = bus_sel & bus_wr;
  wire wr_ctrl   = wr_any & (bus_addr == 3'd0);
  wire wr_ie     = wr_any & (bus_addr == 3'd2);
  wire wr_sample = wr_any & (bus_addr == 3'd3);
  wire wr_period = wr_any & (bus_addr == 3'd4);

  logic src_tick;
  always_comb
    case (src_sel)
      2'd0:    src_tick = 1'b0;
      2'd1:    src_tick = 1'b1;
      2'd2:    src_tick = hf_tick;
      default: src_tick = lf_tick;
    endcase

  wire [2:0]  reps_m1 = 3'((4'd1 << rep_sel) - 4'd1);
  wire [CW:0] per_end = {1'b0, period_q} + (CW+1)'(1);
  wire        step    = running & src_tick & (pre_cnt == presc);
  wire        wrap    = step & (cnt == per_end);
  wire        start   = en & ~running;
  wire        load    = start | (wrap & (rep_cnt == reps_m1));
  wire        pop     = load & (fcnt != '0);
  wire        push    = wr_sample & (fcnt != CNTW'(FDEPTH));

  wire [CNTW-1:0] slots = CNTW'(FDEPTH) - fcnt;
  wire            wm    = slots >= (CNTW'(wm_sel) + CNTW'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl_q <= '0;
    else if (swrst)   ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ie_q     <= '0;
      period_q <= '0;
    end else begin
      if (wr_ie)     ie_q     <= bus_wdata;
      if (wr_period) period_q <= bus_wdata[CW-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      pre_cnt <= '0;
      rep_cnt <= '0;
    end else if (swrst || !en) begin
      running <= 1'b0;
      cnt     <= '0;
      pre_cnt <= '0;
      rep_cnt <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
      pre_cnt <= '0;
      rep_cnt <= '0;
    end else if (running && src_tick) begin
      if (pre_cnt == presc) begin
        pre_cnt <= '0;
        cnt     <= wrap ? '0 : cnt + (CW+1)'(1);
        if (wrap) rep_cnt <= (rep_cnt == reps_m1) ? 3'd0 : rep_cnt + 3'd1;
      end else begin
        pre_cnt <= pre_cnt + PW'(1);
      end
    end

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= bus_wdata[CW-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fcnt   <= '0;
    end else if (swrst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      fcnt   <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      fcnt <= fcnt + CNTW'(push) - CNTW'(pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   duty_q <= '0;
    else if (pop) duty_q <= mem[rd_ptr];

  always_comb
    case (bus_addr)
      3'd0:    bus_rdata = ctrl_q;
      3'd1:    bus_rdata = 32'({wm, fcnt == '0, fcnt});
      3'd2:    bus_rdata = ie_q;
      3'd3:    bus_rdata = 32'(duty_q);
      3'd4:    bus_rdata = 32'(period_q);
      3'd5:    bus_rdata = 32'(cnt[CW-1:0]);
      default: bus_rdata = '0;
    endcase

  assign pwm_out = pol ^ (running & (cnt < {1'b0, duty_q}));
  assign irq     = ie_q[0] & wm;
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk #(
  parameter int CW     = 16,
  parameter int FDEPTH = 4,
  parameter int CNTW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            swrst,
  input logic            en,
  input logic            running,
  input logic [1:0]      src_sel,
  input logic [CW:0]     cnt,
  input logic [CW-1:0]   duty_q,
  input logic [CNTW-1:0] fcnt,
  input logic            pol,
  input logic            pwm_out,
  input logic            irq
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt != '0) |-> (cnt == $past(cnt) || cnt == $past(cnt) + (CW+1)'(1))); // R2
  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> (pwm_out == pol)); // R3
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && en && !swrst && src_sel == 2'd0) |=> $stable(cnt)); // R5
  AST_FIFO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= CNTW'(FDEPTH)); // R6
  AST_FULL_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt == CNTW'(FDEPTH)) |-> !irq); // R9
  AST_SWRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> (fcnt == '0 && !en && !swrst)); // R10
  AST_IDLE_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0)); // R11
endmodule

bind bl_pwm bl_pwm_chk #(.CW(CW), .FDEPTH(FDEPTH), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n), .swrst(swrst), .en(en), .running(running),
  .src_sel(src_sel), .cnt(cnt), .duty_q(duty_q), .fcnt(fcnt), .pol(pol),
  .pwm_out(pwm_out), .irq(irq)
);

// File: tb/bl_pwm_test.sv
module bl_pwm_test;
  localparam int CLK_NS = 10;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_IE = 3'd2,
                         A_SMP = 3'd3, A_PER = 3'd4, A_CNT = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0, hf_tick = 1'b0, lf_tick = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:2] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic pwm_out, irq;
  int n_chk = 0, n_bad = 0;
  bit pol_tb = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  bl_pwm uut (.clk(clk), .rst_n(rst_n), .hf_tick(hf_tick), .lf_tick(lf_tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out), .irq(irq));

  function automatic logic [31:0] mk(int en, int rep, int pre, int src, int pol, int wm);
    return 32'(en) | 32'(rep << 1) | 32'(pre << 4) | 32'(src << 16) | 32'(pol << 18) | 32'(wm << 26);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int d);
    bus_addr = a;
    #1 d = int'(bus_rdata);
  endtask

  task automatic soft_reset;
    wr(A_CTRL, 32'h8);
    @(negedge clk); @(negedge clk);
    pol_tb = 1'b0;
  endtask

  task automatic wait_rise;
    bit p, c;
    c = pwm_out ^ pol_tb;
    do begin
      p = c;
      @(negedge clk);
      c = pwm_out ^ pol_tb;
    end while (!(p == 1'b0 && c == 1'b1));
  endtask

  // Called on the first active cycle of a period; returns on the first of the next one.
  task automatic meas(output int hi, output int tot);
    hi = 0; tot = 0;
    while ((pwm_out ^ pol_tb) == 1'b1) begin hi++; tot++; @(negedge clk); end
    while ((pwm_out ^ pol_tb) == 1'b0) begin tot++; @(negedge clk); end
  endtask

  task automatic pulse(bit hf, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (hf) hf_tick = 1'b1; else lf_tick = 1'b1;
      @(negedge clk);
      hf_tick = 1'b0; lf_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, hi, tot;
    int seq[5];
    int unsigned seed_v;
    seed_v = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 'h18);
    rd(A_IE, v);   chk("R1 ie", v, 0);
    rd(A_SMP, v);  chk("R1 sample", v, 0);
    rd(A_PER, v);  chk("R1 period", v, 0);
    rd(A_CNT, v);  chk("R1 counter", v, 0);
    chk("R1 pwm_out", int'(pwm_out), 0);
    chk("R1 irq", int'(irq), 0);

    // R2 random period, duty and prescaler on the bus clock
    for (int it = 0; it < 8; it++) begin
      int p, s, d;
      p = 2 + int'($urandom % 39);
      s = 1 + int'($urandom % (p + 1));
      d = int'($urandom % 4);
      soft_reset();
      wr(A_PER, 32'(p));
      wr(A_SMP, 32'(s));
      wr(A_CTRL, mk(1, 0, d, 1, 0, 0));
      wait_rise();
      meas(hi, tot);
      chk("R2 active time", hi, s * (d + 1));
      chk("R2 period", tot, (p + 2) * (d + 1));
      meas(hi, tot);
      chk("R2 second period", tot, (p + 2) * (d + 1));
    end
    // R2 directed: duty just below full period
    soft_reset();
    wr(A_PER, 32'd5); wr(A_SMP, 32'd6);
    wr(A_CTRL, mk(1, 0, 0, 1, 0, 0));
    wait_rise(); meas(hi, tot);
    chk("R2 max duty active", hi, 6);
    chk("R2 max duty period", tot, 7);

    // R3 zero sample
    soft_reset();
    wr(A_PER, 32'd10); wr(A_SMP, 32'd0);
    wr(A_CTRL, mk(1, 0, 0, 1, 0, 0));
    hi = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); hi += int'(pwm_out); end
    chk("R3 zero sample stays low", hi, 0);

    // R4 polarity
    soft_reset();
    wr(A_CTRL, mk(0, 0, 0, 1, 1, 0));
    @(negedge clk);
    chk("R4 idle level inverted", int'(pwm_out), 1);
    wr(A_PER, 32'd30); wr(A_SMP, 32'd7);
    pol_tb = 1'b1;
    wr(A_CTRL, mk(1, 0, 0, 1, 1, 0));
    wait_rise(); meas(hi, tot);
    chk("R4 inverted active time", hi, 7);
    chk("R4 inverted period", tot, 32);

    // R5 time base selection
    soft_reset();
    wr(A_PER, 32'd100); wr(A_SMP, 32'd50);
    wr(A_CTRL, mk(1, 0, 0, 0, 0, 0));
    repeat (20) @(negedge clk);
    rd(A_CNT, v); chk("R5 source off holds counter", v, 0);
    wr(A_CTRL, mk(1, 0, 0, 2, 0, 0));
    pulse(1'b0, 3);
    rd(A_CNT, v); chk("R5 lf strobe ignored on hf source", v, 0);
    pulse(1'b1, 7);
    rd(A_CNT, v); chk("R5 hf strobes counted", v, 7);
    wr(A_CTRL, mk(1, 0, 0, 3, 0, 0));
    pulse(1'b1, 4);
    rd(A_CNT, v); chk("R5 hf strobe ignored on lf source", v, 7);
    pulse(1'b0, 3);
    rd(A_CNT, v); chk("R5 lf strobes counted", v, 10);

    // R6 overflow drop and order, R8 reuse when empty, R11 sample readback
    soft_reset();
    wr(A_SMP, 32'd10); wr(A_SMP, 32'd20); wr(A_SMP, 32'd30);
    wr(A_SMP, 32'd40); wr(A_SMP, 32'd50);
    rd(A_STAT, v); chk("R6 full queue status", v, 'h04);
    wr(A_PER, 32'd60);
    wr(A_CTRL, mk(1, 0, 0, 1, 0, 0));
    seq = '{10, 20, 30, 40, 40};
    wait_rise();
    for (int k = 0; k < 5; k++) begin
      meas(hi, tot);
      chk(k < 4 ? "R6 queue order" : "R8 last sample reused", hi, seq[k]);
    end
    rd(A_STAT, v); chk("R8 empty status", v, 'h18);
    rd(A_SMP, v);  chk("R11 active sample readback", v, 40);

    // R7 repeat counts
    for (int rs = 1; rs <= 2; rs++) begin
      int n;
      n = 1 << rs;
      soft_reset();
      wr(A_SMP, 32'd3); wr(A_SMP, 32'd6);
      wr(A_PER, 32'd12);
      wr(A_CTRL, mk(1, rs, 0, 1, 0, 0));
      wait_rise();
      for (int k = 0; k <= n; k++) begin
        meas(hi, tot);
        chk("R7 repeat sequence", hi, (k < n) ? 3 : 6);
      end
    end

    // R9 watermark and irq
    soft_reset();
    wr(A_IE, 32'd1);
    wr(A_CTRL, mk(0, 0, 0, 0, 0, 0));
    wr(A_SMP, 32'd1); wr(A_SMP, 32'd2); wr(A_SMP, 32'd3);
    rd(A_STAT, v); chk("R9 one slot free, threshold 1", v, 'h13);
    chk("R9 irq with watermark", int'(irq), 1);
    wr(A_SMP, 32'd4);
    rd(A_STAT, v); chk("R9 no slot free", v, 'h04);
    chk("R9 irq low when full", int'(irq), 0);
    soft_reset();
    wr(A_CTRL, mk(0, 0, 0, 0, 0, 3));
    rd(A_STAT, v); chk("R9 threshold 4 on empty", v, 'h18);
    wr(A_SMP, 32'd9);
    rd(A_STAT, v); chk("R9 threshold 4 with one entry", v, 'h01);
    chk("R9 irq low below threshold", int'(irq), 0);
    wr(A_CTRL, mk(0, 0, 0, 0, 0, 1));
    wr(A_IE, 32'd0);
    rd(A_STAT, v); chk("R9 threshold 2 with one entry", v, 'h11);
    chk("R9 irq masked", int'(irq), 0);

    // R10 soft reset
    soft_reset();
    wr(A_PER, 32'd40); wr(A_SMP, 32'd5); wr(A_SMP, 32'd8);
    wr(A_CTRL, mk(1, 0, 0, 1, 0, 0));
    repeat (15) @(negedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h9;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(A_CTRL, v); chk("R10 reset bit visible one cycle", v, 'h9);
    @(negedge clk);
    rd(A_CTRL, v); chk("R10 control cleared", v, 0);
    rd(A_STAT, v); chk("R10 queue cleared", v, 'h18);
    rd(A_CNT, v);  chk("R10 counter cleared", v, 0);
    chk("R10 output idle", int'(pwm_out), 0);
    rd(A_PER, v);  chk("R11 period readback", v, 40);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule